// File: doc/BRIEF.md
# Dual-Port Serial Memory Bank Router

This block sits between two independent two-wire serial slave engines and two 256-byte memory banks. A registered mode flag, taken from an active-low mode input, selects how the ports reach the storage. In split mode each port owns one bank and answers its own 3-bit slave sub-address, and both ports may access their banks in the same cycle. In merged mode port 1 reaches both banks as one 512-byte space, and port 2 is silenced.

The slave engines hand the router the 7-bit device address they received and are told whether to acknowledge. In merged mode the lowest bit of that device address acts as address bit 8 and is kept as the bank selector for port 1's later accesses. The router also gates every memory write with the active-low write-protect input, reports that gating back to the engines, and returns read data from the correct bank one cycle after a request.

Top module: `dbank_router`

## Requirements
- R1: `mode_comb_o` is 1 (merged) when `mode_n_i` was low and 0 (split) when it was high. It loads during reset. After reset it only updates on a clock edge where port 1 is not busy, port 2 is not busy (port 2 busy is ignored while merged), and `wcyc_i` is all zero. Otherwise it holds.
- R2: In split mode a port 1 request goes only to bank 0 and a port 2 request goes only to bank 1, both at the port's 8-bit word address. Requests on both ports in the same cycle are served together.
- R3: In split mode, a port hits when its device byte has bits [6:3] = 4'b1010 and bits [2:0] equal that port's sub-address parameter (default 3'b000 for both).
- R4: In merged mode, port 1 hits when bits [6:3] = 4'b1010, whatever bits [2:1] are. On a hit, bit 0 is stored as A8 on `p1_bank_o`, and later port 1 accesses go to bank 0 (A8 = 0) or bank 1 (A8 = 1). A hit in split mode clears `p1_bank_o`.
- R5: In merged mode, port 2 never hits, its requests reach no bank, `p2_rdata_o` reads zero and `p2_wr_en_o` is 0.
- R6: While `wp_n_i` is low, no bank write enable is raised and `p1_wr_en_o`/`p2_wr_en_o` are 0. Reads still return stored data.
- R7: Both modes share one storage. Bank 1 word w in split mode is merged address 0x100+w, and bank 0 word w is merged address w.
- R8: While a target bank's internal write is running, no hit is given. In split mode this means `wcyc_i[0]` for port 1 and `wcyc_i[1]` for port 2. In merged mode, port 1 needs both bits clear.
- R9: Read data for a request appears on the port's read-data output in the cycle after the request, taken from the bank selected when the request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| mode_n_i | input | 1 | Mode select, low = merged, high = split |
| wp_n_i | input | 1 | Write protect, low blocks all writes |
| wcyc_i | input | 2 | Per-bank internal write cycle in progress |
| p1_busy_i | input | 1 | Port 1 engine inside a transaction |
| p1_dev_vld_i | input | 1 | Port 1 device byte valid |
| p1_dev_i | input | 7 | Port 1 device address (without R/W) |
| p1_hit_o | output | 1 | Port 1 should acknowledge |
| p1_bank_o | output | 1 | Port 1 stored A8 bank selector |
| p1_wr_en_o | output | 1 | Port 1 writes permitted |
| p1_req_i | input | 1 | Port 1 memory access strobe |
| p1_we_i | input | 1 | Port 1 access is a write |
| p1_word_i | input | 8 | Port 1 word address |
| p1_wdata_i | input | 8 | Port 1 write data |
| p1_rdata_o | output | 8 | Port 1 read data |
| p2_busy_i | input | 1 | Port 2 engine inside a transaction |
| p2_dev_vld_i | input | 1 | Port 2 device byte valid |
| p2_dev_i | input | 7 | Port 2 device address (without R/W) |
| p2_hit_o | output | 1 | Port 2 should acknowledge |
| p2_wr_en_o | output | 1 | Port 2 writes permitted |
| p2_req_i | input | 1 | Port 2 memory access strobe |
| p2_we_i | input | 1 | Port 2 access is a write |
| p2_word_i | input | 8 | Port 2 word address |
| p2_wdata_i | input | 8 | Port 2 write data |
| p2_rdata_o | output | 8 | Port 2 read data |
| bk_en_o | output | 2 | Per-bank access enable |
| bk_we_o | output | 2 | Per-bank write enable |
| bk_addr_o | output | 16 | Per-bank word address, bank b at [8b+7:8b] |
| bk_wdata_o | output | 16 | Per-bank write data, bank b at [8b+7:8b] |
| bk_rdata_i | input | 16 | Per-bank registered read data |
| mode_comb_o | output | 1 | Registered mode, 1 = merged |

## Verification
Every cycle, the assertions check that the mode flag stays put while a port or a write cycle is active. They also check that write protect holds every bank write enable low, that port 2 stays silent in merged mode, and that a busy bank refuses acknowledges. They further check that a merged port 1 access touches exactly one bank and that simultaneous split-mode accesses reach both banks. Only the bench scenarios can show that data lands at the right address and comes back one cycle later. They also show that bytes written in merged mode are read back unchanged in split mode, that ignored port 2 writes leave storage untouched, and that the don't-care sub-address bits really match.

// File: rtl/dbr_pkg.sv
// Shared constants for the dual-port bank router.
// Assumes two banks and the fixed 4-bit device code.
package dbr_pkg;
    localparam int NBANK    = 2;
    localparam int BSEL_W   = $clog2(NBANK);
    localparam int WORD_W   = 8;
    localparam int DATA_W   = 8;
    localparam int DEV_W    = 7;
    localparam int SUB_W    = 3;
    localparam int CODE_W   = DEV_W - SUB_W;
    localparam logic [CODE_W-1:0] DEV_CODE = 4'b1010;
    localparam int PRI_BANK = 0;
    localparam int SEC_BANK = 1;

    // Mode encoding carried on the registered mode flag
    typedef enum logic {
        MODE_SPLIT  = 1'b0,
        MODE_MERGED = 1'b1
    } dbr_mode_e;
endpackage

// File: rtl/dbr_mode_reg.sv
// Mode register: samples the active-low mode pin into a flag.
// Loads during reset, then only when the caller reports full idleness.
// Assumes idle_i already folds in port activity and bank write cycles.
module dbr_mode_reg
    import dbr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic mode_n_i,
    input  logic idle_i,
    output logic comb_o
);
    dbr_mode_e mode_q;

    // Sample the pin at reset or whenever everything is quiet
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            mode_q <= mode_n_i ? MODE_SPLIT : MODE_MERGED;
        end else if (idle_i) begin
            mode_q <= mode_n_i ? MODE_SPLIT : MODE_MERGED;
        end
    end

    assign comb_o = (mode_q == MODE_MERGED);
endmodule

// File: rtl/dbr_addr_match.sv
// Device-address matcher for one port.
// PRIMARY=1: port that survives merged mode (sub-address upper bits
// ignored, bit 0 is A8, needs every bank free). PRIMARY=0: port that
// only exists in split mode. Combinational; assumes dev_i is stable
// while vld_i is high.
module dbr_addr_match
    import dbr_pkg::*;
#(
    parameter logic [SUB_W-1:0] OWN_SUB  = '0,
    parameter bit               PRIMARY  = 1'b1,
    parameter int               OWN_BANK = PRI_BANK
) (
    input  logic             comb_i,
    input  logic             vld_i,
    input  logic [DEV_W-1:0] dev_i,
    input  logic [NBANK-1:0] wbusy_i,
    output logic             hit_o
);
    logic code_ok;
    logic sub_ok;
    logic own_free;
    logic all_free;

    // Split the device byte into code and sub-address checks
    always_comb begin
        code_ok  = (dev_i[DEV_W-1 -: CODE_W] == DEV_CODE);
        sub_ok   = (dev_i[SUB_W-1:0] == OWN_SUB);
        own_free = !wbusy_i[OWN_BANK];
        all_free = !(|wbusy_i);
    end

    generate
        if (PRIMARY) begin : g_primary
            // Merged: only the code matters; split: full sub-address
            always_comb begin
                if (comb_i) hit_o = vld_i && code_ok && all_free;
                else        hit_o = vld_i && code_ok && sub_ok && own_free;
            end
        end else begin : g_secondary
            // Secondary port is mute in merged mode
            always_comb begin
                hit_o = vld_i && !comb_i && code_ok && sub_ok && own_free;
            end
        end
    endgenerate
endmodule

// File: rtl/dbr_bank_steer.sv
// Bank steering: routes port requests onto per-bank strobes, gates
// writes with write protect, and returns registered read data.
// Assumes banks present read data one cycle after an enabled access
// and that port 1 and port 2 never target the same bank in a cycle.
module dbr_bank_steer
    import dbr_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_n_i,
    input  logic                      comb_i,
    input  logic                      wp_n_i,
    input  logic                      p1_req_i,
    input  logic                      p1_we_i,
    input  logic [BSEL_W-1:0]         p1_sel_i,
    input  logic [WORD_W-1:0]         p1_word_i,
    input  logic [DATA_W-1:0]         p1_wdata_i,
    output logic [DATA_W-1:0]         p1_rdata_o,
    input  logic                      p2_req_i,
    input  logic                      p2_we_i,
    input  logic [WORD_W-1:0]         p2_word_i,
    input  logic [DATA_W-1:0]         p2_wdata_i,
    output logic [DATA_W-1:0]         p2_rdata_o,
    output logic [NBANK-1:0]          bk_en_o,
    output logic [NBANK-1:0]          bk_we_o,
    output logic [NBANK*WORD_W-1:0]   bk_addr_o,
    output logic [NBANK*DATA_W-1:0]   bk_wdata_o,
    input  logic [NBANK*DATA_W-1:0]   bk_rdata_i
);
    logic [DATA_W-1:0] rd_a [NBANK];
    logic [BSEL_W-1:0] p1_rsel_q;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic              from1;
            logic              from2;
            logic              we_raw;
            logic [WORD_W-1:0] addr_b;
            logic [DATA_W-1:0] wdat_b;

            // Decide which port owns this bank in the current cycle
            always_comb begin
                from1 = p1_req_i && (p1_sel_i == BSEL_W'(b));
                from2 = (b == SEC_BANK) && p2_req_i && !comb_i;
            end

            // Mux the owning port's access onto the bank
            always_comb begin
                if (from1) begin
                    we_raw = p1_we_i;
                    addr_b = p1_word_i;
                    wdat_b = p1_wdata_i;
                end else begin
                    we_raw = from2 && p2_we_i;
                    addr_b = p2_word_i;
                    wdat_b = p2_wdata_i;
                end
            end

            assign bk_en_o[b]                     = from1 || from2;
            assign bk_we_o[b]                     = (from1 || from2) && we_raw && wp_n_i;
            assign bk_addr_o[b*WORD_W +: WORD_W]  = addr_b;
            assign bk_wdata_o[b*DATA_W +: DATA_W] = wdat_b;
            assign rd_a[b]                        = bk_rdata_i[b*DATA_W +: DATA_W];
        end
    endgenerate

    // Remember which bank port 1 read so the return data follows it
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)      p1_rsel_q <= '0;
        else if (p1_req_i) p1_rsel_q <= p1_sel_i;
    end

    // Return paths: port 1 via stored select, port 2 fixed and muted when merged
    always_comb begin
        p1_rdata_o = rd_a[p1_rsel_q];
        p2_rdata_o = comb_i ? '0 : rd_a[SEC_BANK];
    end
endmodule

// File: rtl/dbank_router.sv
// Dual-port bank router top: mode register, two device matchers,
// the port 1 A8 bank selector and the bank steering.
// Assumes external slave engines raise busy for a whole transaction
// and present memory requests only after a hit.
module dbank_router
    import dbr_pkg::*;
#(
    parameter logic [SUB_W-1:0] P1_SUB = 3'b000,
    parameter logic [SUB_W-1:0] P2_SUB = 3'b000
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic                    mode_n_i,
    input  logic                    wp_n_i,
    input  logic [NBANK-1:0]        wcyc_i,
    input  logic                    p1_busy_i,
    input  logic                    p1_dev_vld_i,
    input  logic [DEV_W-1:0]        p1_dev_i,
    output logic                    p1_hit_o,
    output logic                    p1_bank_o,
    output logic                    p1_wr_en_o,
    input  logic                    p1_req_i,
    input  logic                    p1_we_i,
    input  logic [WORD_W-1:0]       p1_word_i,
    input  logic [DATA_W-1:0]       p1_wdata_i,
    output logic [DATA_W-1:0]       p1_rdata_o,
    input  logic                    p2_busy_i,
    input  logic                    p2_dev_vld_i,
    input  logic [DEV_W-1:0]        p2_dev_i,
    output logic                    p2_hit_o,
    output logic                    p2_wr_en_o,
    input  logic                    p2_req_i,
    input  logic                    p2_we_i,
    input  logic [WORD_W-1:0]       p2_word_i,
    input  logic [DATA_W-1:0]       p2_wdata_i,
    output logic [DATA_W-1:0]       p2_rdata_o,
    output logic [NBANK-1:0]        bk_en_o,
    output logic [NBANK-1:0]        bk_we_o,
    output logic [NBANK*WORD_W-1:0] bk_addr_o,
    output logic [NBANK*DATA_W-1:0] bk_wdata_o,
    input  logic [NBANK*DATA_W-1:0] bk_rdata_i,
    output logic                    mode_comb_o
);
    logic              comb;
    logic              idle;
    logic [BSEL_W-1:0] a8_q;
    logic [BSEL_W-1:0] p1_sel;

    // Quiet when no port transaction and no bank write cycle is running
    always_comb begin
        idle = !p1_busy_i && (comb || !p2_busy_i) && !(|wcyc_i);
    end

    dbr_mode_reg u_mode (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .mode_n_i(mode_n_i),
        .idle_i  (idle),
        .comb_o  (comb)
    );

    dbr_addr_match #(
        .OWN_SUB (P1_SUB),
        .PRIMARY (1'b1),
        .OWN_BANK(PRI_BANK)
    ) u_match1 (
        .comb_i (comb),
        .vld_i  (p1_dev_vld_i),
        .dev_i  (p1_dev_i),
        .wbusy_i(wcyc_i),
        .hit_o  (p1_hit_o)
    );

    dbr_addr_match #(
        .OWN_SUB (P2_SUB),
        .PRIMARY (1'b0),
        .OWN_BANK(SEC_BANK)
    ) u_match2 (
        .comb_i (comb),
        .vld_i  (p2_dev_vld_i),
        .dev_i  (p2_dev_i),
        .wbusy_i(wcyc_i),
        .hit_o  (p2_hit_o)
    );

    // Capture A8 from the device byte on every port 1 hit
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)      a8_q <= '0;
        else if (p1_hit_o) a8_q <= comb ? BSEL_W'(p1_dev_i[0]) : '0;
    end

    // Port 1 bank target: A8 in merged mode, its own bank otherwise
    always_comb begin
        p1_sel = comb ? a8_q : BSEL_W'(PRI_BANK);
    end

    dbr_bank_steer u_steer (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .comb_i    (comb),
        .wp_n_i    (wp_n_i),
        .p1_req_i  (p1_req_i),
        .p1_we_i   (p1_we_i),
        .p1_sel_i  (p1_sel),
        .p1_word_i (p1_word_i),
        .p1_wdata_i(p1_wdata_i),
        .p1_rdata_o(p1_rdata_o),
        .p2_req_i  (p2_req_i),
        .p2_we_i   (p2_we_i),
        .p2_word_i (p2_word_i),
        .p2_wdata_i(p2_wdata_i),
        .p2_rdata_o(p2_rdata_o),
        .bk_en_o   (bk_en_o),
        .bk_we_o   (bk_we_o),
        .bk_addr_o (bk_addr_o),
        .bk_wdata_o(bk_wdata_o),
        .bk_rdata_i(bk_rdata_i)
    );

    assign p1_bank_o   = a8_q[0];
    assign p1_wr_en_o  = wp_n_i;
    assign p2_wr_en_o  = wp_n_i && !comb;
    assign mode_comb_o = comb;
endmodule

// File: rtl/dbank_router_chk.sv
// Property checker for dbank_router, attached by bind below.
module dbank_router_chk
    import dbr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              mode_comb_o,
    input logic              wp_n_i,
    input logic [NBANK-1:0]  wcyc_i,
    input logic              p1_busy_i,
    input logic              p1_dev_vld_i,
    input logic              p1_hit_o,
    input logic              p2_dev_vld_i,
    input logic              p2_hit_o,
    input logic              p1_req_i,
    input logic              p2_req_i,
    input logic [DATA_W-1:0] p2_rdata_o,
    input logic [NBANK-1:0]  bk_en_o,
    input logic [NBANK-1:0]  bk_we_o
);
    // R1: mode flag frozen while port 1 or a write cycle is active
    p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (p1_busy_i || (|wcyc_i)) |=> $stable(mode_comb_o));

    // R2: split mode with both ports requesting reaches both banks
    p_split_both_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!mode_comb_o && p1_req_i && p2_req_i) |-> (bk_en_o == 2'b11));

    // R4: merged port 1 access touches exactly one bank
    p_merged_one_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mode_comb_o && p1_req_i) |-> ($countones(bk_en_o) == 1));

    // R5: port 2 is silent in merged mode
    p_p2_mute_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        mode_comb_o |-> (!p2_hit_o && p2_rdata_o == '0));

    // R6: write protect blocks every bank write
    p_wp_block_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wp_n_i |-> (bk_we_o == '0));

    // R8: busy bank refuses acknowledges
    p_p1_busy_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wcyc_i[PRI_BANK] && p1_dev_vld_i) |-> !p1_hit_o);

    p_p2_busy_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wcyc_i[SEC_BANK] && p2_dev_vld_i) |-> !p2_hit_o);
endmodule

bind dbank_router dbank_router_chk u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .mode_comb_o (mode_comb_o),
    .wp_n_i      (wp_n_i),
    .wcyc_i      (wcyc_i),
    .p1_busy_i   (p1_busy_i),
    .p1_dev_vld_i(p1_dev_vld_i),
    .p1_hit_o    (p1_hit_o),
    .p2_dev_vld_i(p2_dev_vld_i),
    .p2_hit_o    (p2_hit_o),
    .p1_req_i    (p1_req_i),
    .p2_req_i    (p2_req_i),
    .p2_rdata_o  (p2_rdata_o),
    .bk_en_o     (bk_en_o),
    .bk_we_o     (bk_we_o)
);

// File: tb/dbank_router_tb.sv
// Bench: behavioural 512-byte reference model compared every cycle.
module dbank_router_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, mode_n, wp_n;
    logic [1:0]  wcyc;
    logic        p1_busy, p1_dev_vld, p1_req, p1_we;
    logic [6:0]  p1_dev;
    logic [7:0]  p1_word, p1_wdata;
    logic        p2_busy, p2_dev_vld, p2_req, p2_we;
    logic [6:0]  p2_dev;
    logic [7:0]  p2_word, p2_wdata;
    logic        p1_hit, p1_bank, p1_wr_en, p2_hit, p2_wr_en, mode_comb;
    logic [7:0]  p1_rdata, p2_rdata;
    logic [1:0]  bk_en, bk_we;
    logic [15:0] bk_addr, bk_wdata, bk_rdata;

    dbank_router u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .mode_n_i(mode_n), .wp_n_i(wp_n),
        .wcyc_i(wcyc),
        .p1_busy_i(p1_busy), .p1_dev_vld_i(p1_dev_vld), .p1_dev_i(p1_dev),
        .p1_hit_o(p1_hit), .p1_bank_o(p1_bank), .p1_wr_en_o(p1_wr_en),
        .p1_req_i(p1_req), .p1_we_i(p1_we), .p1_word_i(p1_word),
        .p1_wdata_i(p1_wdata), .p1_rdata_o(p1_rdata),
        .p2_busy_i(p2_busy), .p2_dev_vld_i(p2_dev_vld), .p2_dev_i(p2_dev),
        .p2_hit_o(p2_hit), .p2_wr_en_o(p2_wr_en),
        .p2_req_i(p2_req), .p2_we_i(p2_we), .p2_word_i(p2_word),
        .p2_wdata_i(p2_wdata), .p2_rdata_o(p2_rdata),
        .bk_en_o(bk_en), .bk_we_o(bk_we), .bk_addr_o(bk_addr),
        .bk_wdata_o(bk_wdata), .bk_rdata_i(bk_rdata), .mode_comb_o(mode_comb)
    );

    // Behavioural banks with one-cycle read latency
    logic [7:0] bm [2][256];
    always @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (bk_en[b]) begin
                bk_rdata[b*8 +: 8] <= bm[b][bk_addr[b*8 +: 8]];
                if (bk_we[b]) bm[b][bk_addr[b*8 +: 8]] <= bk_wdata[b*8 +: 8];
            end
        end
    end

    // Reference model state
    int mm [512];
    bit m_comb, m_a8, pv1, pv2;
    int pd1, pd2;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit code_ok(input logic [6:0] d);
        return d[6:3] == 4'b1010;
    endfunction

    // One cycle: compare outputs, advance the model, cross a clock edge
    task automatic step();
        bit e1, e2;
        int a1, a2;
        #1;
        e1 = p1_dev_vld && code_ok(p1_dev) &&
             (m_comb ? (wcyc == 2'b00) : (p1_dev[2:0] == 3'b000 && !wcyc[0]));
        e2 = p2_dev_vld && !m_comb && code_ok(p2_dev) && p2_dev[2:0] == 3'b000 && !wcyc[1];
        chk(mode_comb, m_comb, "R1 mode flag");
        chk(p1_hit, e1, "R3 R4 R8 port1 hit");
        chk(p2_hit, e2, "R3 R5 R8 port2 hit");
        chk(p1_bank, m_a8, "R4 A8 latch");
        chk(p1_wr_en, wp_n, "R6 port1 write permit");
        chk(p2_wr_en, wp_n && !m_comb, "R5 R6 port2 write permit");
        if (pv1) chk(p1_rdata, pd1, "R2 R7 R9 port1 read");
        if (m_comb) chk(p2_rdata, 0, "R5 port2 muted");
        else if (pv2) chk(p2_rdata, pd2, "R2 R7 R9 port2 read");
        // next state
        pv1 = 0; pv2 = 0;
        if (p1_req) begin
            a1 = ((m_comb && m_a8) ? 256 : 0) + p1_word;
            pd1 = mm[a1]; pv1 = !p1_we;
            if (p1_we && wp_n) mm[a1] = p1_wdata;
        end
        if (p2_req && !m_comb) begin
            a2 = 256 + p2_word;
            pd2 = mm[a2]; pv2 = !p2_we;
            if (p2_we && wp_n) mm[a2] = p2_wdata;
        end
        if (e1) m_a8 = m_comb ? p1_dev[0] : 1'b0;
        if (!p1_busy && (m_comb || !p2_busy) && wcyc == 2'b00) m_comb = !mode_n;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        p1_dev_vld = 0; p1_req = 0; p1_we = 0;
        p2_dev_vld = 0; p2_req = 0; p2_we = 0;
    endtask

    task automatic dev(input bit port, input logic [6:0] d);
        clr();
        if (port == 0) begin p1_dev_vld = 1; p1_dev = d; end
        else begin p2_dev_vld = 1; p2_dev = d; end
        step(); clr();
    endtask

    task automatic acc(input bit port, input bit we, input logic [7:0] w, input logic [7:0] d);
        clr();
        if (port == 0) begin p1_req = 1; p1_we = we; p1_word = w; p1_wdata = d; end
        else begin p2_req = 1; p2_we = we; p2_word = w; p2_wdata = d; end
        step(); clr();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mm[i] = 8'hFF;
        for (int i = 0; i < 256; i++) begin bm[0][i] = 8'hFF; bm[1][i] = 8'hFF; end
        bk_rdata = '0;
        rst_n = 0; mode_n = 1; wp_n = 1; wcyc = 0;
        p1_busy = 0; p2_busy = 0; p1_dev = 0; p2_dev = 0;
        p1_word = 0; p2_word = 0; p1_wdata = 0; p2_wdata = 0;
        clr();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1; m_comb = 0; m_a8 = 0;
        step();                                   // R1 reset state: split

        // R3 split-mode matching
        p1_busy = 1; p2_busy = 1;
        clr(); p1_dev_vld = 1; p1_dev = 7'b1010000; p2_dev_vld = 1; p2_dev = 7'b1010000;
        step(); clr();
        dev(0, 7'b1010001); dev(1, 7'b0110000); dev(1, 7'b1010100);

        // R2 concurrent accesses to separate banks
        clr(); p1_req = 1; p1_we = 1; p1_word = 8'h10; p1_wdata = 8'h5A;
        p2_req = 1; p2_we = 1; p2_word = 8'h10; p2_wdata = 8'hA5; step();
        clr(); p1_req = 1; p1_word = 8'h10; p2_req = 1; p2_word = 8'h10; step();
        clr(); step();
        for (int i = 0; i < 4; i++) acc(0, 1, 8'h20 + 8'(i), 8'h30 + 8'(i));

        // R6 write protect
        wp_n = 0;
        acc(0, 1, 8'h10, 8'h00); acc(1, 1, 8'h10, 8'h00);
        acc(0, 0, 8'h10, 0); acc(1, 0, 8'h10, 0); step();
        wp_n = 1;

        // R8 busy banks refuse
        wcyc = 2'b01; clr(); p1_dev_vld = 1; p1_dev = 7'b1010000;
        p2_dev_vld = 1; p2_dev = 7'b1010000; step();
        wcyc = 2'b10; step(); clr(); wcyc = 0;

        // R1 mode held while busy or writing
        mode_n = 0; step(); step();
        p1_busy = 0; step(); step();
        p2_busy = 0; wcyc = 2'b01; step(); step();
        wcyc = 0; step(); step();

        // R4 merged mode with don't-care sub bits, A8 = 1
        p1_busy = 1; p2_busy = 1;
        dev(0, 7'b1010111);
        acc(0, 1, 8'h10, 8'h77); acc(0, 0, 8'h10, 0);
        // R5 port 2 ignored
        dev(1, 7'b1010000);
        acc(1, 1, 8'h30, 8'h99); acc(1, 0, 8'h30, 0);
        // R4 A8 = 0 and wrong code
        dev(0, 7'b1010100);
        acc(0, 0, 8'h10, 0); acc(0, 1, 8'h40, 8'h3C);
        dev(0, 7'b1110001);
        // R8 merged needs both banks free
        wcyc = 2'b10; dev(0, 7'b1010001); wcyc = 0;
        step();

        // R7 back to split mode, read merged writes
        p1_busy = 0; p2_busy = 0; mode_n = 1; step(); step();
        p1_busy = 1; p2_busy = 1;
        acc(1, 0, 8'h10, 0); acc(1, 0, 8'h30, 0); acc(0, 0, 8'h40, 0);
        for (int i = 0; i < 4; i++) acc(0, 0, 8'h20 + 8'(i), 0);
        step();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule